// File: doc/BRIEF.md
# 64-bit Integer to Single-Precision Float Converter

The converter takes a 64-bit integer and returns the nearest IEEE-754 single-precision value. A mode input chooses how the operand is read. When it is set, the operand is a two's-complement number. When it is clear, the operand is an unsigned magnitude. Results that cannot be held exactly are rounded to nearest, and a halfway case goes to the value with an even fraction.

Each operand arrives with a strobe. The result, with a strobe of its own, is available on the next clock edge. The datapath has four parts:

- a sign stage, which negates a negative operand one 32-bit word at a time with a carry passed upward;
- a leading-one search, made of one detector per 32-bit word;
- a left shift that places the leading one at the top of the word;
- a rounding adder that works on the exponent and fraction together, so a fraction overflow moves into the exponent.

Top module: `i2f_convert`

## Requirements
- R1: An operand of zero gives +0.0 (0x00000000), in both modes.
- R2: For a non-zero magnitude whose highest set bit is at index k (0 to 63), bits [30:23] of the result hold 127+k. Bits [22:0] hold the 23 magnitude bits below that leading one. This holds exactly when the magnitude fits in 24 significant bits.
- R3: When the discarded bits are worth more than half a unit in the last fraction place, the result rounds away from zero in magnitude.
- R4: When the discarded bits are worth exactly half a unit, the fraction with bit 0 equal to zero is chosen (ties to even).
- R5: A round-up that overflows the 23-bit fraction gives a zero fraction and an exponent one higher. For example, 2^25-1 gives 0x4C000000 and 2^64-1 gives 0x5F800000.
- R6: With the signed mode input high and operand bit 63 set, the magnitude is the two's-complement negation of the operand and bit 31 of the result is 1. For example, -2^63 gives 0xDF000000 and -1 gives 0xBF800000. With the signed mode input low, bit 31 of the result is always 0.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. out_float changes only on an edge where in_valid was high, and holds its value otherwise.
- R8: While rst is high at a clock edge, out_valid and out_float are cleared to zero on that edge.
- R9: Operands whose upper 32 bits are zero convert by the same rules. For example, 2^32-1 rounds to 0x4F800000 and 1 gives 0x3F800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Integer operand |
| in_signed | input | 1 | 1 = two's-complement operand, 0 = unsigned |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_float | output | 32 | Single-precision result |

## Verification
Every internal fault shows up in the same output word that one operand produces, on the edge after its strobe, because nothing is stored between operands. Each fault gives a typical pattern:

- A wrong leading-one index moves the exponent by whole powers of two.
- A broken carry in the negation shows up only for negative operands whose low word is zero.
- A faulty tie or sticky decision changes only bit 0 of the result, or the exponent on a carry.

For this reason the vectors aim at halfway cases on both sides of the 32-bit word boundary. Every result is also compared with an arithmetic model written in the bench.

// File: rtl/i2f_pkg.sv
`timescale 1ns/1ps
package i2f_pkg;
    localparam int DATA_W  = 64;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = DATA_W / WORD_W;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int BIAS    = 127;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int WIDX_W  = $clog2(WORD_W);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int TAIL_W  = DATA_W - SIG_W;

    typedef struct packed {
        logic              neg;
        logic [DATA_W-1:0] mag;
    } magnitude_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } lead_t;

    // exponent (without the implicit +1 from the hidden bit) for a lead index
    function automatic logic [EXP_W-1:0] exp_base(input logic [IDX_W-1:0] idx);
        return EXP_W'(BIAS - 1) + EXP_W'(idx);
    endfunction
endpackage

// File: rtl/i2f_magnitude.sv
`timescale 1ns/1ps
module i2f_magnitude
    import i2f_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic              is_signed,
    output magnitude_t        mag_o
);
    logic              neg;
    logic [N_WORDS:0]  carry;
    logic [DATA_W-1:0] negated;

    assign neg      = is_signed & data[DATA_W-1];
    assign carry[0] = 1'b1;

    // invert-plus-one, one word at a time with a carry passed upward
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [WORD_W:0] sum;
        assign sum = {1'b0, ~data[w*WORD_W +: WORD_W]} + {{WORD_W{1'b0}}, carry[w]};
        assign negated[w*WORD_W +: WORD_W] = sum[WORD_W-1:0];
        assign carry[w+1] = sum[WORD_W];
    end

    assign mag_o.neg = neg;
    assign mag_o.mag = neg ? negated : data;
endmodule

// File: rtl/i2f_lead_one.sv
`timescale 1ns/1ps
module i2f_lead_one #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/i2f_round_pack.sv
`timescale 1ns/1ps
module i2f_round_pack
    import i2f_pkg::*;
(
    input  magnitude_t  mag_i,
    input  lead_t       lead_i,
    output logic [31:0] result
);
    logic [IDX_W-1:0]       shamt;
    logic [DATA_W-1:0]      norm;
    logic [SIG_W-1:0]       sig;
    logic [TAIL_W-1:0]      tail;
    logic                   half_bit;
    logic                   below_half;
    logic [EXP_W+FRAC_W-1:0] packed_w;
    logic [EXP_W+FRAC_W-1:0] rounded;

    assign shamt = IDX_W'(DATA_W - 1) - lead_i.idx;
    assign norm  = mag_i.mag << shamt;
    assign sig   = norm[DATA_W-1 -: SIG_W];
    assign tail  = norm[TAIL_W-1:0];

    assign half_bit   = tail[TAIL_W-1];
    assign below_half = |tail[TAIL_W-2:0];

    // hidden bit lands on the exponent LSB and lifts exp_base to its final value
    assign packed_w = {exp_base(lead_i.idx), {FRAC_W{1'b0}}}
                    + {{(EXP_W-1){1'b0}}, sig};

    always_comb begin
        rounded = packed_w + {{(EXP_W+FRAC_W-1){1'b0}}, half_bit};
        if (half_bit && !below_half)
            rounded[0] = 1'b0;
    end

    assign result = lead_i.found ? {mag_i.neg, rounded} : 32'h0;
endmodule

// File: rtl/i2f_convert.sv
`timescale 1ns/1ps
module i2f_convert
    import i2f_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_signed,
    output logic              out_valid,
    output logic [31:0]       out_float
);
    magnitude_t        mag;
    lead_t             lead;
    logic [N_WORDS-1:0] word_found;
    logic [WIDX_W-1:0]  word_idx [N_WORDS];
    logic [31:0]        result;

    i2f_magnitude u_mag (
        .data      (in_data),
        .is_signed (in_signed),
        .mag_o     (mag)
    );

    for (genvar w = 0; w < N_WORDS; w++) begin : g_lod
        i2f_lead_one #(.W(WORD_W), .IW(WIDX_W)) u_lod (
            .vec   (mag.mag[w*WORD_W +: WORD_W]),
            .found (word_found[w]),
            .idx   (word_idx[w])
        );
    end

    // highest word holding a one decides the lead index
    always_comb begin
        lead.found = 1'b0;
        lead.idx   = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (word_found[w]) begin
                lead.found = 1'b1;
                lead.idx   = IDX_W'(w * WORD_W) + IDX_W'(word_idx[w]);
            end
        end
    end

    i2f_round_pack u_rnd (
        .mag_i  (mag),
        .lead_i (lead),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_float <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_float <= result;
        end
    end
endmodule

// File: rtl/i2f_convert_chk.sv
`timescale 1ns/1ps
module i2f_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic        in_signed,
    input logic        out_valid,
    input logic [31:0] out_float
);
    p_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_float == 32'h0));

    p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_float));

    p_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == 64'h0) |=> out_float == 32'h0);

    p_unsigned_pos_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_signed) |=> !out_float[31]);

    p_negative_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_signed && in_data[63]) |=> out_float[31]);

    p_exp_range_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data != 64'h0) |=>
            (out_float[30:23] >= 8'd127 && out_float[30:23] <= 8'd191));
endmodule

bind i2f_convert i2f_convert_chk i_chk (.*);

// File: tb/test_i2f_convert.sv
`timescale 1ns/1ps
module test_i2f_convert;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_signed = 1'b0;
    logic        out_valid;
    logic [31:0] out_float;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    i2f_convert i_i2f_convert (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_signed(in_signed), .out_valid(out_valid), .out_float(out_float)
    );

    // {operand, signed mode, expected result}
    localparam logic [96:0] VECS [15] = '{
        {64'h0000_0000_0000_0000, 1'b0, 32'h0000_0000},   // R1
        {64'h0000_0000_0000_0001, 1'b0, 32'h3F80_0000},   // R9
        {64'h0000_0000_0100_0001, 1'b0, 32'h4B80_0000},   // R4 tie, even kept
        {64'h0000_0000_0100_0003, 1'b0, 32'h4B80_0002},   // R4 tie, odd rounds up
        {64'h0000_0000_01FF_FFFF, 1'b0, 32'h4C00_0000},   // R5
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 32'h5F80_0000},   // R5
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 32'hBF80_0000},   // R6
        {64'h8000_0000_0000_0000, 1'b1, 32'hDF00_0000},   // R6
        {64'h8000_0000_0000_0000, 1'b0, 32'h5F00_0000},   // R6 unsigned
        {64'h0000_0001_0000_0000, 1'b0, 32'h4F80_0000},   // R2
        {64'h0000_0000_FFFF_FFFF, 1'b0, 32'h4F80_0000},   // R9 / R3
        {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 32'hC000_0000},   // R6
        {64'h0000_0100_0001_0000, 1'b0, 32'h5380_0000},   // R4 across words
        {64'h0000_0100_0003_0000, 1'b0, 32'h5380_0002},   // R4 across words
        {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 32'h5F00_0000}    // R3
    };

    function automatic logic [31:0] ref_conv(input logic [63:0] d, input logic s);
        logic        neg;
        logic [63:0] m, q, rem, half;
        int          msb;
        neg = s && d[63];
        m   = neg ? (~d + 64'd1) : d;
        msb = -1;
        for (int i = 0; i < 64; i++) if (m[i]) msb = i;
        if (msb < 0) return 32'h0;
        if (msb <= 23) begin
            q = m << (23 - msb);
        end else begin
            q    = m >> (msb - 23);
            rem  = m - (q << (msb - 23));
            half = 64'd1 << (msb - 24);
            if (rem > half || (rem == half && q[0])) q = q + 64'd1;
            if (q == (64'd1 << 24)) begin
                q   = q >> 1;
                msb = msb + 1;
            end
        end
        return {neg, 8'(msb + 127), q[22:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [63:0] d, input logic s, input logic [31:0] exp, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_signed = s;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 strobe", {31'h0, out_valid}, 32'h1);
        check(req, out_float, exp);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] lfsr;
        logic [63:0] d;
        logic [31:0] held;
        lfsr = 64'h9E37_79B9_7F4A_7C15;

        repeat (3) @(negedge clk);
        check("R8 reset valid", {31'h0, out_valid}, 32'h0);
        check("R8 reset data", out_float, 32'h0);
        rst = 1'b0;

        foreach (VECS[i]) begin
            convert(VECS[i][96:33], VECS[i][32], VECS[i][31:0], "R2-table");
            check("R3 model", out_float, ref_conv(VECS[i][96:33], VECS[i][32]));
        end

        // R7: hold and idle after a strobe
        convert(64'd12345, 1'b0, 32'h4640_E400, "R2 exact");
        held = out_float;
        in_data = 64'hDEAD_BEEF_0000_0001;
        in_signed = 1'b1;
        @(negedge clk);
        check("R7 idle", {31'h0, out_valid}, 32'h0);
        check("R7 hold", out_float, held);

        // R7: back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; in_data = 64'd3; in_signed = 1'b0;
        @(negedge clk);
        check("R7 b2b first", out_float, 32'h4040_0000);
        in_data = 64'hFFFF_FFFF_FFFF_FFFD; in_signed = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 b2b second", out_float, 32'hC040_0000);

        // R1 signed zero
        convert(64'h0, 1'b1, 32'h0, "R1 signed zero");

        // random operands over a spread of magnitudes
        for (int n = 0; n < 400; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            d = lfsr >> (n % 64);
            convert(d, lfsr[3], ref_conv(d, lfsr[3]), "R3/R4 random");
        end

        // R8: reset mid-stream clears the result
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_data = 64'd7;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R8 sync reset valid", {31'h0, out_valid}, 32'h0);
        check("R8 sync reset data", out_float, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule